// File: doc/BRIEF.md
# Transition-Coded Two-Wire Token Receiver

This block receives tokens over a pair of wires in which each bit is carried by a change of level rather than by the level itself. A change on the "one" wire means a 1 and a change on the "zero" wire means a 0. Both wires rest low between tokens. A token is nine bits long: eight data bits, most significant first, followed by a control flag. After the ninth bit the sender returns both wires to low. That closing change marks the end of the token.

The sender runs from its own clock. The receiver therefore takes no fixed sampling schedule. It synchronises both wires into its own clock domain and acts on each change as it is observed. It aligns to token boundaries by watching for the all-low rest state. After any error it first waits for that state, and a long silence in the middle of a token also drops the receiver back to waiting for it. Each finished token appears on the output for exactly one clock cycle, together with an error flag.

Top module: `wirepair_token_rx`

## Requirements
- R1: During reset and in the first cycle after it, `tok_valid`, `tok_err`, `tok_ctrl` and `tok_data` are all 0. Outside a `tok_valid` pulse these outputs stay 0.
- R2: Each observed change on `one_wire` is decoded as bit value 1 and each change on `zero_wire` as bit value 0, whichever direction the wire moves.
- R3: The first decoded bit of a token lands in `tok_data[7]`, the following seven bits land in `tok_data[6]` down to `tok_data[0]`, and the ninth bit lands in `tok_ctrl`.
- R4: When the change that follows the ninth bit leaves both wires low, `tok_valid` is high for exactly one cycle with `tok_err` = 0. The pulse is seen after the second rising edge following the edge that first samples that closing change, which is three cycles after the input changes between edges.
- R5: When the change that follows the ninth bit leaves either wire high, a single `tok_valid` pulse is produced with `tok_err` = 1 and with data and control 0. The receiver then waits for the rest state.
- R6: When both wires change in the same sampled cycle within the first nine bits, a `tok_valid` pulse with `tok_err` = 1 and with data and control 0 is produced, and the partial token is discarded.
- R7: After an error or an abandoned token, changes are ignored until both wires are seen low. The next departure from rest is then taken as bit 7 of a new token.
- R8: Once a token has started, IDLE_LIMIT consecutive sampled cycles with no change abandon it without any pulse. Changes spaced up to IDLE_LIMIT cycles apart still complete the token.
- R9: While the pair rests low with no change, no pulse is produced.
- R10: Decoding does not depend on bit spacing. Changes one cycle apart and changes many cycles apart give the same token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_wire | input | 1 | Asynchronous wire whose changes carry 0 bits |
| one_wire | input | 1 | Asynchronous wire whose changes carry 1 bits |
| tok_valid | output | 1 | One-cycle strobe marking a finished token or an error |
| tok_data | output | 8 | Eight data bits of the token, first received bit in the top position |
| tok_ctrl | output | 1 | Ninth received bit, the control flag |
| tok_err | output | 1 | Set with the strobe when the token failed its closing or framing check |

## Verification
The tests send tokens of all zeros, all ones and mixed values. This separates a decoder that reads which wire moved from one that reads wire levels, because the zero wire rises and falls repeatedly within one token. Bit spacing runs from one cycle up to exactly IDLE_LIMIT cycles, showing that decoding does not depend on rate and that the timeout boundary sits where specified. Damaged tokens come in three kinds: a wrong closing change, a simultaneous change on both wires, and a token cut off by silence. Each is followed by a clean token, which shows whether the receiver realigned on the rest state or carried stale bits into the next token.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_REST = 2'd0,
        ST_IDLE      = 2'd1,
        ST_RECV      = 2'd2,
        ST_CHECK     = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic one;
        logic zero;
    } wire_pair_t;

    function automatic logic pair_at_rest(wire_pair_t p);
        return !(p.one || p.zero);
    endfunction

    function automatic logic pair_any(wire_pair_t p);
        return p.one || p.zero;
    endfunction

    function automatic logic pair_both(wire_pair_t p);
        return p.one && p.zero;
    endfunction

endpackage

// File: rtl/wpr_pair_sync.sv
module wpr_pair_sync
    import wpr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  wire_pair_t raw,
    output wire_pair_t level,
    output wire_pair_t chg
);

    wire_pair_t stage_q [STAGES];
    wire_pair_t prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign level = stage_q[STAGES-1];
    assign chg   = wire_pair_t'(stage_q[STAGES-1] ^ prev_q);

endmodule

// File: rtl/wpr_token_shift.sv
module wpr_token_shift #(
    parameter int BITS = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            first,
    input  logic            bit_in,
    output logic [BITS-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (load) begin
            if (first) word <= {{(BITS-1){1'b0}}, bit_in};
            else       word <= {word[BITS-2:0], bit_in};
        end
    end

endmodule

// File: rtl/wpr_rx_ctrl.sv
module wpr_rx_ctrl
    import wpr_pkg::*;
#(
    parameter int BITS       = 9,
    parameter int IDLE_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  wire_pair_t level,
    input  wire_pair_t chg,
    output logic       shift_en,
    output logic       shift_first,
    output logic       bit_val,
    output logic       emit,
    output logic       emit_err,
    output rx_state_e  state_q
);

    localparam int CNT_W = $clog2(BITS + 1);
    localparam int QW    = (IDLE_LIMIT > 2) ? $clog2(IDLE_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);
    localparam logic [QW-1:0]    LAST_Q   = QW'(IDLE_LIMIT - 1);

    rx_state_e        state_d;
    logic [CNT_W-1:0] bits_q, bits_d;
    logic [QW-1:0]    quiet_q, quiet_d;

    assign bit_val = chg.one;

    always_comb begin
        state_d     = state_q;
        bits_d      = bits_q;
        quiet_d     = quiet_q;
        shift_en    = 1'b0;
        shift_first = 1'b0;
        emit        = 1'b0;
        emit_err    = 1'b0;
        unique case (state_q)
            ST_WAIT_REST: begin
                if (pair_at_rest(level)) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (pair_any(chg)) begin
                    if (pair_both(chg)) begin
                        emit     = 1'b1;
                        emit_err = 1'b1;
                        state_d  = ST_WAIT_REST;
                    end else begin
                        shift_en    = 1'b1;
                        shift_first = 1'b1;
                        bits_d      = CNT_W'(1);
                        quiet_d     = '0;
                        state_d     = ST_RECV;
                    end
                end
            end
            ST_RECV: begin
                if (pair_any(chg)) begin
                    if (pair_both(chg)) begin
                        emit     = 1'b1;
                        emit_err = 1'b1;
                        state_d  = ST_WAIT_REST;
                    end else begin
                        shift_en = 1'b1;
                        quiet_d  = '0;
                        if (bits_q == LAST_BIT) state_d = ST_CHECK;
                        else                    bits_d  = bits_q + CNT_W'(1);
                    end
                end else if (quiet_q == LAST_Q) begin
                    state_d = ST_WAIT_REST;
                end else begin
                    quiet_d = quiet_q + QW'(1);
                end
            end
            ST_CHECK: begin
                if (pair_any(chg)) begin
                    emit = 1'b1;
                    if (pair_at_rest(level)) begin
                        state_d = ST_IDLE;
                    end else begin
                        emit_err = 1'b1;
                        state_d  = ST_WAIT_REST;
                    end
                end else if (quiet_q == LAST_Q) begin
                    state_d = ST_WAIT_REST;
                end else begin
                    quiet_d = quiet_q + QW'(1);
                end
            end
            default: state_d = ST_WAIT_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_REST;
            bits_q  <= '0;
            quiet_q <= '0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            quiet_q <= quiet_d;
        end
    end

endmodule

// File: rtl/wirepair_token_rx.sv
module wirepair_token_rx
    import wpr_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIMIT  = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 zero_wire,
    input  logic                 one_wire,
    output logic                 tok_valid,
    output logic [DATA_BITS-1:0] tok_data,
    output logic                 tok_ctrl,
    output logic                 tok_err
);

    localparam int TOKEN_BITS = DATA_BITS + 1;

    wire_pair_t            raw;
    wire_pair_t            level;
    wire_pair_t            chg;
    logic                  shift_en;
    logic                  shift_first;
    logic                  bit_val;
    logic                  emit;
    logic                  emit_err;
    rx_state_e             state;
    logic [TOKEN_BITS-1:0] word;

    assign raw.one  = one_wire;
    assign raw.zero = zero_wire;

    wpr_pair_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw),
        .level (level),
        .chg   (chg)
    );

    wpr_rx_ctrl #(.BITS(TOKEN_BITS), .IDLE_LIMIT(IDLE_LIMIT)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .level       (level),
        .chg         (chg),
        .shift_en    (shift_en),
        .shift_first (shift_first),
        .bit_val     (bit_val),
        .emit        (emit),
        .emit_err    (emit_err),
        .state_q     (state)
    );

    wpr_token_shift #(.BITS(TOKEN_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (shift_en),
        .first  (shift_first),
        .bit_in (bit_val),
        .word   (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_valid <= 1'b0;
            tok_err   <= 1'b0;
            tok_data  <= '0;
            tok_ctrl  <= 1'b0;
        end else begin
            tok_valid <= emit;
            tok_err   <= emit && emit_err;
            if (emit && !emit_err) {tok_data, tok_ctrl} <= word;
            else                   {tok_data, tok_ctrl} <= '0;
        end
    end

endmodule

// File: rtl/wirepair_token_rx_chk.sv
module wirepair_token_rx_chk
    import wpr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input rx_state_e  state,
    input wire_pair_t level,
    input wire_pair_t chg,
    input logic       tok_valid,
    input logic       tok_err
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tok_valid && !tok_err));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tok_valid |=> !tok_valid);

    a_r4_clean_close: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && chg != 2'b00 && level == 2'b00) |=> (tok_valid && !tok_err));

    a_r5_bad_close: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && chg != 2'b00 && level != 2'b00) |=> (tok_valid && tok_err));

    a_r6_both_changed: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE || state == ST_RECV) && chg == 2'b11) |=> (tok_valid && tok_err));

    a_r7_hold_until_rest: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_REST && level != 2'b00) |=> (!tok_valid && state == ST_WAIT_REST));

    a_r9_rest_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && chg == 2'b00) |=> !tok_valid);

endmodule

bind wirepair_token_rx wirepair_token_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .level     (level),
    .chg       (chg),
    .tok_valid (tok_valid),
    .tok_err   (tok_err)
);

// File: tb/wirepair_token_rx_bench.sv
module wirepair_token_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zero_w = 1'b0;
    logic       one_w  = 1'b0;
    logic       tok_valid;
    logic [7:0] tok_data;
    logic       tok_ctrl;
    logic       tok_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    wirepair_token_rx #(.DATA_BITS(8), .SYNC_STAGES(2), .IDLE_LIMIT(LIMIT)) u_wirepair_token_rx (
        .clk       (clk),
        .rst       (rst),
        .zero_wire (zero_w),
        .one_wire  (one_w),
        .tok_valid (tok_valid),
        .tok_data  (tok_data),
        .tok_ctrl  (tok_ctrl),
        .tok_err   (tok_err)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    string cur_req = "R1";

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: sampled wire history, decoded token by token
    logic [1:0] h1 = 0, h2 = 0, h3 = 0, h4 = 0;
    int         m_mode = 0;
    int         acc = 0, nb = 0, quiet = 0;
    logic       exp_v = 0, exp_c = 0, exp_e = 0;
    logic [7:0] exp_d = 0;

    always @(posedge clk) begin
        logic [1:0] cur, ch;
        cyc++;
        exp_v = 0; exp_c = 0; exp_e = 0; exp_d = 0;
        if (rst) begin
            h1 = 0; h2 = 0; h3 = 0; h4 = 0;
            m_mode = 0; acc = 0; nb = 0; quiet = 0;
        end else begin
            h4 = h3; h3 = h2; h2 = h1; h1 = {one_w, zero_w};
            cur = h3;
            ch  = h3 ^ h4;
            case (m_mode)
                0: if (cur == 2'b00) m_mode = 1;
                1: if (ch != 0) begin
                       if (ch == 2'b11) begin exp_v = 1; exp_e = 1; m_mode = 0; end
                       else begin acc = ch[1]; nb = 1; quiet = 0; m_mode = 2; end
                   end
                2: if (ch != 0) begin
                       if (ch == 2'b11) begin exp_v = 1; exp_e = 1; m_mode = 0; end
                       else begin
                           acc = (acc << 1) | ch[1]; nb++; quiet = 0;
                           if (nb == 9) m_mode = 3;
                       end
                   end else begin
                       quiet++;
                       if (quiet >= LIMIT) m_mode = 0;
                   end
                default: if (ch != 0) begin
                       exp_v = 1;
                       if (cur != 2'b00) begin exp_e = 1; m_mode = 0; end
                       else begin exp_d = 8'((acc >> 1) & 8'hFF); exp_c = acc[0]; m_mode = 1; end
                   end else begin
                       quiet++;
                       if (quiet >= LIMIT) m_mode = 0;
                   end
            endcase
        end
    end

    // capture of strobes and per-cycle comparison
    int         got_cnt = 0;
    int         got_cyc = 0;
    logic [7:0] got_d = 0;
    logic       got_c = 0, got_e = 0;
    logic       last_v = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(tok_valid == exp_v && tok_data == exp_d && tok_ctrl == exp_c && tok_err == exp_e,
                cur_req, "cycle model {v,d,c,e}",
                int'({tok_valid, tok_data, tok_ctrl, tok_err}), int'({exp_v, exp_d, exp_c, exp_e}));
            if (tok_valid) begin
                got_cnt++; got_cyc = cyc;
                got_d = tok_data; got_c = tok_ctrl; got_e = tok_err;
                chk(!last_v, "R4", "strobe longer than one cycle", 1, 0);
            end
            last_v = tok_valid;
        end
    end

    always @(posedge clk) begin
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int rest_cyc = 0;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flip(bit b);
        @(negedge clk);
        if (b) one_w = ~one_w;
        else   zero_w = ~zero_w;
    endtask

    task automatic send_bits(int val9, int n, int gap);
        for (int i = 0; i < n; i++) begin
            flip(bit'((val9 >> (8 - i)) & 1));
            if (i != n - 1) tick(gap - 1);
        end
    endtask

    task automatic rest_pair();
        @(negedge clk);
        one_w = 1'b0; zero_w = 1'b0;
        rest_cyc = cyc;
    endtask

    task automatic send_token(int d, bit c, int gap);
        send_bits((d << 1) | c, 9, gap);
        tick(gap - 1);
        rest_pair();
        tick(6);
    endtask

    task automatic expect_token(int n0, int d, bit c, string req);
        chk(got_cnt == n0 + 1, req, "strobe count", got_cnt - n0, 1);
        chk(got_d == 8'(d), req, "data", got_d, d);
        chk(got_c == c, req, "control flag", got_c, c);
        chk(got_e == 1'b0, req, "error flag", got_e, 0);
    endtask

    task automatic expect_error(int n0, string req);
        chk(got_cnt == n0 + 1, req, "error strobe count", got_cnt - n0, 1);
        chk(got_e == 1'b1, req, "error flag", got_e, 1);
        chk(got_d == 8'h00 && got_c == 1'b0, req, "data zeroed on error", {got_d, got_c}, 0);
    endtask

    initial begin
        int n0;
        rst = 1'b1;
        tick(4);
        rst = 1'b0;
        @(negedge clk);
        chk(!tok_valid && !tok_err && tok_data == 0 && !tok_ctrl, "R1", "outputs after reset",
            int'({tok_valid, tok_data, tok_ctrl, tok_err}), 0);

        cur_req = "R9"; n0 = got_cnt;
        tick(20);
        chk(got_cnt == n0, "R9", "pulses while resting", got_cnt - n0, 0);

        cur_req = "R3"; n0 = got_cnt;
        send_token(8'hA5, 1'b0, 3);
        expect_token(n0, 8'hA5, 1'b0, "R3");
        chk(got_cyc - rest_cyc == 3, "R4", "closing latency", got_cyc - rest_cyc, 3);

        cur_req = "R2"; n0 = got_cnt;
        send_token(8'h00, 1'b1, 2);
        expect_token(n0, 8'h00, 1'b1, "R2");

        cur_req = "R10"; n0 = got_cnt;
        send_token(8'hFF, 1'b0, 1);
        expect_token(n0, 8'hFF, 1'b0, "R10");

        cur_req = "R8"; n0 = got_cnt;
        send_token(8'h3C, 1'b1, LIMIT);
        expect_token(n0, 8'h3C, 1'b1, "R8");

        cur_req = "R5"; n0 = got_cnt;
        send_bits((8'h12 << 1) | 1, 9, 2);
        tick(1);
        flip(1'b0);
        tick(6);
        expect_error(n0, "R5");
        rest_pair(); tick(4);
        cur_req = "R7"; n0 = got_cnt;
        send_token(8'h5A, 1'b1, 2);
        expect_token(n0, 8'h5A, 1'b1, "R7");

        cur_req = "R6"; n0 = got_cnt;
        send_bits(9'b110_000000, 3, 2);
        tick(1);
        @(negedge clk); one_w = ~one_w; zero_w = ~zero_w;
        tick(6);
        expect_error(n0, "R6");
        cur_req = "R7"; n0 = got_cnt;
        for (int k = 0; k < 4; k++) begin flip(1'b0); tick(1); end
        tick(6);
        chk(got_cnt == n0, "R7", "pulses before rest seen", got_cnt - n0, 0);
        rest_pair(); tick(4);
        send_token(8'h81, 1'b0, 3);
        expect_token(n0, 8'h81, 1'b0, "R7");

        cur_req = "R8"; n0 = got_cnt;
        send_bits(9'b000_000000, 2, 2);
        tick(LIMIT + 5);
        send_token(8'hC3, 1'b0, 2);
        expect_token(n0, 8'hC3, 1'b0, "R8");

        n0 = got_cnt;
        send_bits(9'b101_000000, 3, 2);
        tick(LIMIT + 5);
        chk(got_cnt == n0, "R8", "pulse from abandoned token", got_cnt - n0, 0);
        rest_pair(); tick(4);
        send_token(8'h7E, 1'b1, 1);
        expect_token(n0, 8'h7E, 1'b1, "R8");

        cur_req = "R9"; n0 = got_cnt;
        tick(30);
        chk(got_cnt == n0, "R9", "pulses while resting at end", got_cnt - n0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule